// File: doc/BRIEF.md
# Serial receiver error status unit

This block holds the receive-enable flag and the three sticky error flags (parity, framing, overrun) of an asynchronous serial receiver. The frame decoder reports errors as single-cycle strobes. Each strobe is gated by its own enable bit in a control word and by the receive-enable flag. When it passes, it sets a sticky flag in a readable state word. Software never writes those flags directly. It sets or clears them only through one-shot command bits in a write-only command word.

The block also stores the receiver's frame configuration: character length, parity sense and stop-bit count. It forwards received characters from the decoder to the next stage only while the receiver is enabled. An error interrupt request is raised for as long as any error flag is set.

Top module: `uart_rxe_status`

## Requirements
- R1: After reset the control word reads 0, the state word reads 0 (receiver disabled, no flags) and the interrupt request is low.
- R2: The control word (address 0) keeps only its defined bits: mode field [2:0], odd parity bit 5, two-stop bit 7, and enables at 16 (parity), 17 (framing), 19 (overrun) and 20 (timeout). All other bits read 0. Mode code 2 drives the 7-bit output high and code 0 drives it low. Bits 5 and 7 drive the odd-parity and two-stop outputs.
- R3: Writing the command word (address 2) with bit 1 sets receive-enable, and writing it with bit 0 clears it. If both bits are written together, the flag is cleared. Receive-enable reads back at state bit 0.
- R4: A parity, framing or overrun strobe sets state bit 16, 17 or 19 respectively. It does so only when its enable bit (16, 17 or 19) is 1 and receive-enable is 1 in that cycle. A set flag stays set until it is cleared.
- R5: Command bits 2, 3 and 5 clear the parity, framing and overrun flags respectively. The other flags are left unchanged.
- R6: If a gated error strobe and a clear command for the same flag arrive in the same cycle, the flag ends up set.
- R7: The interrupt request is high exactly when at least one error flag is set.
- R8: While receive-enable is 0, incoming characters are dropped and the valid output stays low. While it is 1, characters pass with their data unchanged, including in a cycle that also carries an overrun strobe.
- R9: The command word reads as 0. Writes to the state word (address 1) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 state, 2 command |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address (same map as write) |
| rd_data | output | 32 | Read data, combinational |
| par_err_i | input | 1 | Parity error strobe from decoder |
| frm_err_i | input | 1 | Framing error strobe from decoder |
| ovr_err_i | input | 1 | Overrun strobe from decoder |
| char_vld_i | input | 1 | Received character valid |
| char_i | input | 8 | Received character |
| char_vld_o | output | 1 | Forwarded character valid |
| char_o | output | 8 | Forwarded character |
| cfg_char7_o | output | 1 | 7-bit mode selected |
| cfg_odd_o | output | 1 | Odd parity selected |
| cfg_two_stop_o | output | 1 | Two stop bits selected |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is a clear command and a gated error strobe landing in the same cycle. The stimulus reaches it by driving the error strobe and the command write from one task at the same falling edge. A full sweep of all enable masks, both receive-enable states and every strobe combination covers the gating. A second sweep of every starting flag pattern against every clear pattern shows that clears leave the other flags untouched.

// File: rtl/uart_rxe_pkg.sv
package uart_rxe_pkg;
   typedef enum logic [1:0] {
      ADDR_CTRL  = 2'd0,
      ADDR_STATE = 2'd1,
      ADDR_CMD   = 2'd2
   } rxe_addr_e;

   localparam int NUM_ERR = 3;  // 0 parity, 1 framing, 2 overrun

   // state word positions
   localparam int ST_RXEN = 0;
   localparam int ST_PAR  = 16;
   localparam int ST_FRM  = 17;
   localparam int ST_OVR  = 19;

   // command word bits
   localparam int CMD_RX_OFF  = 0;
   localparam int CMD_RX_ON   = 1;
   localparam int CMD_CLR_PAR = 2;
   localparam int CMD_CLR_FRM = 3;
   localparam int CMD_CLR_OVR = 5;

   // control word bits
   localparam int CT_ODD  = 5;
   localparam int CT_STOP = 7;
   localparam int CT_PEN  = 16;
   localparam int CT_FEN  = 17;
   localparam int CT_OEN  = 19;
   localparam int CT_TEN  = 20;
   localparam logic [2:0] MODE_8BIT = 3'd0;
   localparam logic [2:0] MODE_7BIT = 3'd2;
   localparam logic [31:0] CTRL_MASK = 32'h001B_00A7;

   localparam int MIN_DATA_W = CT_TEN + 1;
endpackage

// File: rtl/uart_rxe_flag.sv
module uart_rxe_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/uart_rxe_ctrl.sv
module uart_rxe_ctrl #(
   parameter int         DATA_W    = 32,
   parameter logic       RXEN_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_on,
   input  logic              rx_off,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              rx_en_q
);
   import uart_rxe_pkg::*;
   localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= wdata & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_en_q <= RXEN_RST;
      else if (rx_off) rx_en_q <= 1'b0;
      else if (rx_on)  rx_en_q <= 1'b1;
   end
endmodule

// File: rtl/uart_rxe_status.sv
module uart_rxe_status #(
   parameter int   DATA_W   = 32,
   parameter int   CHAR_W   = 8,
   parameter logic RXEN_RST = 1'b0,
   parameter logic IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              par_err_i,
   input  logic              frm_err_i,
   input  logic              ovr_err_i,
   input  logic              char_vld_i,
   input  logic [CHAR_W-1:0] char_i,
   output logic              char_vld_o,
   output logic [CHAR_W-1:0] char_o,
   output logic              cfg_char7_o,
   output logic              cfg_odd_o,
   output logic              cfg_two_stop_o,
   output logic              err_irq_o
);
   import uart_rxe_pkg::*;

   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("DATA_W too small for control/state layout");
   end
   if (CHAR_W < 7) begin : g_bad_char
      $error("CHAR_W must hold a 7-bit character");
   end

   localparam int ST_POS  [NUM_ERR] = '{ST_PAR, ST_FRM, ST_OVR};
   localparam int CLR_POS [NUM_ERR] = '{CMD_CLR_PAR, CMD_CLR_FRM, CMD_CLR_OVR};
   localparam int EN_POS  [NUM_ERR] = '{CT_PEN, CT_FEN, CT_OEN};

   logic              ctrl_wr, cmd_wr;
   logic [DATA_W-1:0] ctrl_q;
   logic              rx_en_q;
   logic [NUM_ERR-1:0] err_evt, evt_en, err_hit, err_clr, err_flag;
   logic [5:0]        cmd_bits;
   logic [DATA_W-1:0] state_word;

   assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
   assign cmd_wr   = wr_en && (wr_addr == ADDR_CMD);
   assign cmd_bits = wr_data[5:0];
   assign err_evt  = {ovr_err_i, frm_err_i, par_err_i};

   uart_rxe_ctrl #(.DATA_W(DATA_W), .RXEN_RST(RXEN_RST)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (ctrl_wr),
      .wdata   (wr_data),
      .rx_on   (cmd_wr && cmd_bits[CMD_RX_ON]),
      .rx_off  (cmd_wr && cmd_bits[CMD_RX_OFF]),
      .ctrl_q  (ctrl_q),
      .rx_en_q (rx_en_q)
   );

   for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
      assign evt_en[i]  = ctrl_q[EN_POS[i]];
      assign err_hit[i] = err_evt[i] && evt_en[i] && rx_en_q;
      assign err_clr[i] = cmd_wr && cmd_bits[CLR_POS[i]];
      uart_rxe_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (err_hit[i]),
         .clr   (err_clr[i]),
         .flag  (err_flag[i])
      );
   end

   always_comb begin
      state_word          = '0;
      state_word[ST_RXEN] = rx_en_q;
      for (int k = 0; k < NUM_ERR; k++) state_word[ST_POS[k]] = err_flag[k];
   end

   always_comb begin
      unique case (rd_addr)
         ADDR_CTRL:  rd_data = ctrl_q;
         ADDR_STATE: rd_data = state_word;
         default:    rd_data = '0;
      endcase
   end

   assign char_vld_o     = char_vld_i && rx_en_q;
   assign char_o         = char_i;
   assign cfg_char7_o    = (ctrl_q[2:0] == MODE_7BIT);
   assign cfg_odd_o      = ctrl_q[CT_ODD];
   assign cfg_two_stop_o = ctrl_q[CT_STOP];

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_irq_o <= 1'b0;
         else        err_irq_o <= |err_flag;
      end
   end else begin : g_irq_comb
      assign err_irq_o = |err_flag;
   end
endmodule

module uart_rxe_status_chk #(
   parameter int NUM_ERR = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_wr,
   input logic [5:0]         cmd_bits,
   input logic               rx_en_q,
   input logic [NUM_ERR-1:0] err_evt,
   input logic [NUM_ERR-1:0] evt_en,
   input logic [NUM_ERR-1:0] err_flag,
   input logic               err_irq_o
);
   p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_bits[0]) |=> !rx_en_q);
   p_set_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_bits[1] && !cmd_bits[0]) |=> rx_en_q);
   p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_irq_o) |-> $past(|(err_evt & evt_en) && rx_en_q));
   p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_irq_o) |-> $past(cmd_wr));

   for (genvar i = 0; i < NUM_ERR; i++) begin : g_chk
      localparam int CB = (i == 0) ? 2 : (i == 1) ? 3 : 5;
      p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (err_flag[i] && !(cmd_wr && cmd_bits[CB])) |=> err_flag[i]);
      p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!err_flag[i] && !(err_evt[i] && evt_en[i] && rx_en_q)) |=> !err_flag[i]);
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_wr && cmd_bits[CB] && !(err_evt[i] && evt_en[i] && rx_en_q)) |=> !err_flag[i]);
      p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (err_evt[i] && evt_en[i] && rx_en_q) |=> err_flag[i]);
   end
endmodule

bind uart_rxe_status uart_rxe_status_chk #(.NUM_ERR(uart_rxe_pkg::NUM_ERR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .cmd_bits  (cmd_bits),
   .rx_en_q   (rx_en_q),
   .err_evt   (err_evt),
   .evt_en    (evt_en),
   .err_flag  (err_flag),
   .err_irq_o (err_irq_o)
);

// File: tb/uart_rxe_status_bench.sv
module uart_rxe_status_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        par_err_i = 1'b0, frm_err_i = 1'b0, ovr_err_i = 1'b0;
   logic        char_vld_i = 1'b0;
   logic [7:0]  char_i = '0;
   logic        char_vld_o;
   logic [7:0]  char_o;
   logic        cfg_char7_o, cfg_odd_o, cfg_two_stop_o, err_irq_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_rxe_status u_uart_rxe_status (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input logic [2:0] ev);
      @(negedge clk);
      {ovr_err_i, frm_err_i, par_err_i} = ev;
      @(negedge clk);
      {ovr_err_i, frm_err_i, par_err_i} = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [31:0] en_word(input logic [2:0] e);
      return {11'd0, e[2], 1'b0, e[1], e[0], 16'd0};
   endfunction
   function automatic logic [31:0] clr_word(input logic [2:0] c);
      return {26'd0, c[2], 1'b0, c[1], c[0], 2'b00};
   endfunction

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, d); check("R1 ctrl", d, 32'h0);
      rd(2'd1, d); check("R1 state", d, 32'h0);
      check("R1 irq", {31'd0, err_irq_o}, 32'h0);
      rst_n = 1'b1;

      // R2 control masking and configuration outputs
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R2 mask", d, 32'h001B_00A7);
      wr(2'd0, 32'h0000_00A2);
      check("R2 cfg", {29'd0, cfg_char7_o, cfg_odd_o, cfg_two_stop_o}, 32'h7);
      wr(2'd0, 32'h0000_0000);
      check("R2 cfg0", {29'd0, cfg_char7_o, cfg_odd_o, cfg_two_stop_o}, 32'h0);

      // R3 receive enable
      wr(2'd2, 32'h2); rd(2'd1, d); check("R3 set", d, 32'h1);
      wr(2'd2, 32'h3); rd(2'd1, d); check("R3 both clears", d, 32'h0);
      wr(2'd2, 32'h2); wr(2'd2, 32'h1); rd(2'd1, d); check("R3 clear", d, 32'h0);

      // R4 / R7 gating sweep
      for (int rx = 0; rx < 2; rx++)
         for (int en = 0; en < 8; en++)
            for (int ev = 0; ev < 8; ev++) begin
               logic [2:0] exp;
               wr(2'd2, 32'h2C | (rx ? 32'h2 : 32'h1));
               wr(2'd0, en_word(3'(en)));
               pulse(3'(ev));
               exp = rx ? 3'(ev & en) : 3'd0;
               rd(2'd1, d);
               check("R4 latch", d, en_word(exp) | 32'(rx));
               check("R7 irq", {31'd0, err_irq_o}, {31'd0, |exp});
               pulse(3'd0);
               rd(2'd1, d);
               check("R4 sticky", d, en_word(exp) | 32'(rx));
            end

      // R5 clear sweep
      wr(2'd0, en_word(3'h7));
      wr(2'd2, 32'h2);
      for (int init = 0; init < 8; init++)
         for (int c = 0; c < 8; c++) begin
            wr(2'd2, 32'h2C);
            pulse(3'(init));
            wr(2'd2, clr_word(3'(c)));
            rd(2'd1, d);
            check("R5 clear", d, en_word(3'(init & ~c)) | 32'h1);
            check("R7 irq", {31'd0, err_irq_o}, {31'd0, |3'(init & ~c)});
         end

      // R6 event and clear in the same cycle
      wr(2'd2, 32'h2C);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h2C;
      {ovr_err_i, frm_err_i, par_err_i} = 3'b101;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      {ovr_err_i, frm_err_i, par_err_i} = '0;
      rd(2'd1, d); check("R6 event wins", d, en_word(3'b101) | 32'h1);

      // R9 command reads zero, state writes ignored
      rd(2'd2, d); check("R9 cmd read", d, 32'h0);
      wr(2'd1, 32'h0000_0000);
      rd(2'd1, d); check("R9 state write", d, en_word(3'b101) | 32'h1);
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd2, 32'h2C);
      rd(2'd1, d); check("R9 state write2", d, 32'h1);

      // R8 character forwarding
      wr(2'd2, 32'h1);
      @(negedge clk);
      char_vld_i = 1'b1; char_i = 8'hA5;
      #1 check("R8 drop", {31'd0, char_vld_o}, 32'h0);
      wr(2'd2, 32'h2);
      @(negedge clk);
      char_i = 8'h3C; ovr_err_i = 1'b1;
      #1 check("R8 pass", {23'd0, char_vld_o, char_o}, {23'd0, 1'b1, 8'h3C});
      @(negedge clk);
      char_vld_i = 1'b0; ovr_err_i = 1'b0;
      rd(2'd1, d); check("R8 ovr flagged", d, en_word(3'b100) | 32'h1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule